// File: doc/BRIEF.md
# MSI Snooping Cache Line Controller

This block is the coherence controller of a small direct-mapped write-back cache that sits on a shared snooping bus. Each frame holds one data word, a tag and one of three coherence states: Invalid, Shared (clean, read-only) or Modified (dirty, the only valid copy, writable). The processor side presents one request at a time, which is a load, a store or an evict. The controller completes the request locally when the frame's state allows it. Otherwise it asks for the bus and issues a read, a read-for-ownership, a data-less upgrade or a writeback.

The bus is treated as atomic. Between a grant and the fill data for that grant, no other transaction appears. The snoop inputs carry only other caches' transactions. When a snooped read or read-for-ownership hits a Modified frame, the controller drives the reply data itself and asserts an inhibit so that memory stays silent. On a snooped read, memory also captures the reply. In every other case memory supplies the data. A request that is waiting for the bus is re-evaluated every cycle against the frame's current state, so a snoop that changes the frame while the request waits also changes what the controller asks for.

A request to an index whose frame holds a different tag replaces that frame. A clean victim is dropped silently. A dirty victim is first written back with its own address.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every frame is Invalid: cpu_done_o, bus_req_o, snp_reply_o and mem_inhibit_o are low, and a first load to any address issues a bus read.
- R2: A load to an Invalid frame requests the bus with command 1 (read). After the grant it waits for fill_valid_i. It completes in the fill cycle, returning fill_data_i on cpu_rdata_o, and the frame becomes Shared.
- R3: A store to an Invalid frame issues command 2 (read-for-ownership). It completes in the fill cycle, and the frame becomes Modified holding the store data, not the fill data.
- R4: A store to a Shared frame issues command 3 (upgrade). It completes in the grant cycle without waiting for fill data, and the frame becomes Modified with the store data.
- R5: Loads to Shared or Modified frames and stores to Modified frames complete in the cycle they are presented, with bus_req_o low. Loads return the frame's data.
- R6: Evicting a Shared or Invalid frame completes silently, and a Shared frame becomes Invalid. Evicting a Modified frame issues command 4 (writeback), with the line's address on bus_addr_o and its data on bus_wdata_o, then completes at the grant and leaves the frame Invalid.
- R7: A snooped read (command 1) that hits a Modified frame raises snp_reply_o and mem_inhibit_o in the same cycle, with the frame's data on snp_data_o. The frame becomes Shared.
- R8: A snooped read-for-ownership (command 2) that hits a Modified frame replies and inhibits the same way. The frame becomes Invalid.
- R9: A Shared frame that snoops command 2 or 3 becomes Invalid. A Shared frame that snoops command 1 stays Shared. A frame that is not Modified never replies or inhibits.
- R10: A load or store to an index whose frame holds another tag replaces it. A Shared victim is dropped silently. A Modified victim is first written back (command 4, the victim's address and data) before the fetch.
- R11: A request waiting for a grant is re-evaluated each cycle. A pending upgrade whose Shared frame is invalidated by a snoop turns into command 2. A pending writeback-eviction whose Modified frame is taken by a snoop completes with no bus request.
- R12: In any cycle with snp_valid_i high, the processor request makes no progress: cpu_done_o and bus_req_o stay low.
- R13: A snooped writeback (command 4), or a snoop whose tag misses the frame, changes no state and drives no reply.
- Address split: the low log2(SETS) bits of an address are the frame index, and the rest is the tag. Processor operations are encoded as 0 load, 1 store, 2 evict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid, held until cpu_done_o |
| cpu_op_i | input | 2 | 0 load, 1 store, 2 evict |
| cpu_addr_i | input | ADDR_W | Request address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_done_o | output | 1 | Request completes at this clock edge |
| cpu_rdata_o | output | DATA_W | Load data, valid with cpu_done_o |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 3 | 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Writeback data |
| bus_gnt_i | input | 1 | Bus grant; the transaction takes place this cycle |
| fill_valid_i | input | 1 | Fill data for an outstanding read or read-for-ownership |
| fill_data_i | input | DATA_W | Fill data |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 3 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_reply_o | output | 1 | This cache sources the reply data |
| snp_data_o | output | DATA_W | Reply data |
| mem_inhibit_o | output | 1 | Memory must not reply |

## Verification
A frame left in the wrong state shows up on the next access to that address. A lost Modified state turns a local store into a bus upgrade or read-for-ownership, and a snooped read then gets no reply. A stale Shared state lets a load complete locally when it should go to the bus. A lost Shared state turns a hit into a bus read. Each of these appears at the ports in the first cycle the next request or snoop is presented, so the bench follows every state-changing event with an access whose bus command or reply exposes the state. Wrong data in a frame appears on cpu_rdata_o, snp_data_o or bus_wdata_o of the next load, snoop reply or writeback.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} line_st_e;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0, CMD_RD = 3'd1, CMD_RDX = 3'd2, CMD_INV = 3'd3, CMD_WB = 3'd4
  } bus_cmd_e;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2} cpu_op_e;
endpackage

// File: rtl/msi_frame_array.sv
module msi_frame_array
  import msi_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output line_st_e          ra_st_o,
  output logic [TAG_W-1:0]  ra_tag_o,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output line_st_e          rb_st_o,
  output logic [TAG_W-1:0]  rb_tag_o,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  line_st_e          w_st_i,
  input  logic              w_full_i,
  input  logic [TAG_W-1:0]  w_tag_i,
  input  logic [DATA_W-1:0] w_data_i
);
  line_st_e          st_q   [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_frame
    logic hit_w;
    assign hit_w = we_i && (w_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]   <= ST_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (hit_w) begin
        st_q[g] <= w_st_i;
        if (w_full_i) begin
          tag_q[g]  <= w_tag_i;
          data_q[g] <= w_data_i;
        end
      end
    end
  end

  assign ra_st_o   = st_q[ra_idx_i];
  assign ra_tag_o  = tag_q[ra_idx_i];
  assign ra_data_o = data_q[ra_idx_i];
  assign rb_st_o   = st_q[rb_idx_i];
  assign rb_tag_o  = tag_q[rb_idx_i];
  assign rb_data_o = data_q[rb_idx_i];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid_i,
  input  bus_cmd_e          snp_cmd_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          f_st_i,
  input  logic [TAG_W-1:0]  f_tag_i,
  input  logic [DATA_W-1:0] f_data_i,
  output logic              reply_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_o,
  output line_st_e          nst_o
);
  logic hit;
  assign hit = snp_valid_i && (f_st_i != ST_I) && (f_tag_i == snp_tag_i);

  always_comb begin
    reply_o = 1'b0;
    nst_o   = f_st_i;
    if (hit) begin
      unique case (f_st_i)
        ST_M: begin
          if (snp_cmd_i == CMD_RD) begin
            reply_o = 1'b1;
            nst_o   = ST_S;
          end else if (snp_cmd_i == CMD_RDX) begin
            reply_o = 1'b1;
            nst_o   = ST_I;
          end else if (snp_cmd_i == CMD_INV) begin
            nst_o = ST_I;  // not reachable with a single owner
          end
        end
        ST_S: begin
          if (snp_cmd_i == CMD_RDX || snp_cmd_i == CMD_INV) nst_o = ST_I;
        end
        default: ;
      endcase
    end
  end

  assign upd_o  = hit && (nst_o != f_st_i);
  assign data_o = reply_o ? f_data_i : '0;
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  cpu_op_e           op_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              stall_i,
  input  line_st_e          f_st_i,
  input  logic [TAG_W-1:0]  f_tag_i,
  input  logic [DATA_W-1:0] f_data_i,
  input  logic              gnt_i,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic [TAG_W-1:0]  bus_tag_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              we_o,
  output line_st_e          w_st_o,
  output logic              w_full_o,
  output logic [DATA_W-1:0] w_data_o
);
  typedef enum logic {PS_RUN, PS_FILL} ps_e;
  ps_e  ps_q, ps_d;
  logic fill_st_q, fill_st_d;

  logic     hit, victim_m;
  line_st_e eff;

  assign hit      = (f_st_i != ST_I) && (f_tag_i == tag_i);
  assign eff      = hit ? f_st_i : ST_I;
  assign victim_m = !hit && (f_st_i == ST_M);

  always_comb begin
    ps_d        = ps_q;
    fill_st_d   = fill_st_q;
    done_o      = 1'b0;
    rdata_o     = f_data_i;
    bus_req_o   = 1'b0;
    bus_cmd_o   = CMD_NONE;
    bus_tag_o   = tag_i;
    bus_wdata_o = '0;
    we_o        = 1'b0;
    w_st_o      = ST_I;
    w_full_o    = 1'b0;
    w_data_o    = wdata_i;

    if (ps_q == PS_FILL) begin
      if (fill_valid_i) begin
        done_o   = 1'b1;
        rdata_o  = fill_data_i;
        we_o     = 1'b1;
        w_full_o = 1'b1;
        w_st_o   = fill_st_q ? ST_M : ST_S;
        w_data_o = fill_st_q ? wdata_i : fill_data_i;
        ps_d     = PS_RUN;
      end
    end else if (req_i && !stall_i) begin
      if (victim_m && op_i != OP_EVICT) begin
        // dirty frame of another tag goes back first
        bus_req_o   = 1'b1;
        bus_cmd_o   = CMD_WB;
        bus_tag_o   = f_tag_i;
        bus_wdata_o = f_data_i;
        if (gnt_i) we_o = 1'b1;
      end else begin
        unique case (op_i)
          OP_LOAD: begin
            if (eff == ST_I) begin
              bus_req_o = 1'b1;
              bus_cmd_o = CMD_RD;
              if (gnt_i) begin
                ps_d      = PS_FILL;
                fill_st_d = 1'b0;
              end
            end else begin
              done_o = 1'b1;
            end
          end
          OP_STORE: begin
            unique case (eff)
              ST_I: begin
                bus_req_o = 1'b1;
                bus_cmd_o = CMD_RDX;
                if (gnt_i) begin
                  ps_d      = PS_FILL;
                  fill_st_d = 1'b1;
                end
              end
              ST_S: begin
                bus_req_o = 1'b1;
                bus_cmd_o = CMD_INV;
                if (gnt_i) begin
                  done_o   = 1'b1;
                  we_o     = 1'b1;
                  w_st_o   = ST_M;
                  w_full_o = 1'b1;
                end
              end
              default: begin
                done_o   = 1'b1;
                we_o     = 1'b1;
                w_st_o   = ST_M;
                w_full_o = 1'b1;
              end
            endcase
          end
          OP_EVICT: begin
            unique case (eff)
              ST_M: begin
                bus_req_o   = 1'b1;
                bus_cmd_o   = CMD_WB;
                bus_wdata_o = f_data_i;
                if (gnt_i) begin
                  done_o = 1'b1;
                  we_o   = 1'b1;
                end
              end
              ST_S: begin
                done_o = 1'b1;
                we_o   = 1'b1;
              end
              default: done_o = 1'b1;
            endcase
          end
          default: done_o = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q      <= PS_RUN;
      fill_st_q <= 1'b0;
    end else begin
      ps_q      <= ps_d;
      fill_st_q <= fill_st_d;
    end
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [1:0]        cpu_op_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_gnt_i,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              snp_valid_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_reply_o,
  output logic [DATA_W-1:0] snp_data_o,
  output logic              mem_inhibit_o
);
  logic [IDX_W-1:0]  req_idx, snp_idx;
  logic [TAG_W-1:0]  req_tag, snp_tag;
  line_st_e          pf_st, sf_st;
  logic [TAG_W-1:0]  pf_tag, sf_tag;
  logic [DATA_W-1:0] pf_data, sf_data;

  logic              snp_upd, snp_reply;
  line_st_e          snp_nst;

  logic              f_we, f_full;
  line_st_e          f_st;
  logic [DATA_W-1:0] f_wdata;
  bus_cmd_e          f_cmd;
  logic [TAG_W-1:0]  f_btag;

  logic              w_en, w_full;
  logic [IDX_W-1:0]  w_idx;
  line_st_e          w_st;

  assign req_idx = cpu_addr_i[IDX_W-1:0];
  assign req_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  msi_frame_array #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_idx_i  (req_idx),
    .ra_st_o   (pf_st),
    .ra_tag_o  (pf_tag),
    .ra_data_o (pf_data),
    .rb_idx_i  (snp_idx),
    .rb_st_o   (sf_st),
    .rb_tag_o  (sf_tag),
    .rb_data_o (sf_data),
    .we_i      (w_en),
    .w_idx_i   (w_idx),
    .w_st_i    (w_st),
    .w_full_i  (w_full),
    .w_tag_i   (req_tag),
    .w_data_i  (f_wdata)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_snoop (
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (bus_cmd_e'(snp_cmd_i)),
    .snp_tag_i   (snp_tag),
    .f_st_i      (sf_st),
    .f_tag_i     (sf_tag),
    .f_data_i    (sf_data),
    .reply_o     (snp_reply),
    .data_o      (snp_data_o),
    .upd_o       (snp_upd),
    .nst_o       (snp_nst)
  );

  msi_req_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .op_i         (cpu_op_e'(cpu_op_i)),
    .tag_i        (req_tag),
    .wdata_i      (cpu_wdata_i),
    .stall_i      (snp_valid_i),
    .f_st_i       (pf_st),
    .f_tag_i      (pf_tag),
    .f_data_i     (pf_data),
    .gnt_i        (bus_gnt_i),
    .fill_valid_i (fill_valid_i),
    .fill_data_i  (fill_data_i),
    .done_o       (cpu_done_o),
    .rdata_o      (cpu_rdata_o),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (f_cmd),
    .bus_tag_o    (f_btag),
    .bus_wdata_o  (bus_wdata_o),
    .we_o         (f_we),
    .w_st_o       (f_st),
    .w_full_o     (f_full),
    .w_data_o     (f_wdata)
  );

  // snoop updates win; the request side is stalled during a snoop
  assign w_en   = snp_upd || f_we;
  assign w_idx  = snp_upd ? snp_idx : req_idx;
  assign w_st   = snp_upd ? snp_nst : f_st;
  assign w_full = !snp_upd && f_full;

  assign bus_cmd_o     = f_cmd;
  assign bus_addr_o    = {f_btag, req_idx};
  assign snp_reply_o   = snp_reply;
  assign mem_inhibit_o = snp_reply;
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_req_i,
  input logic       cpu_done_o,
  input logic       bus_req_o,
  input logic [2:0] bus_cmd_o,
  input logic       bus_gnt_i,
  input logic       fill_valid_i,
  input logic       snp_valid_i,
  input logic [2:0] snp_cmd_i,
  input logic       snp_reply_o,
  input logic       mem_inhibit_o
);
  p_reply_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_reply_o |-> snp_valid_i && (snp_cmd_i == 3'd1 || snp_cmd_i == 3'd2));

  p_silent_snoop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && (snp_cmd_i == 3'd3 || snp_cmd_i == 3'd4) |-> !snp_reply_o && !mem_inhibit_o);

  p_upgrade_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i && bus_req_o && bus_cmd_o == 3'd3 |-> cpu_done_o);

  p_fetch_waits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i && bus_req_o && (bus_cmd_o == 3'd1 || bus_cmd_o == 3'd2) |-> !cpu_done_o ##1 !bus_req_o);

  p_snoop_stall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !cpu_done_o && !bus_req_o);

  p_bus_from_cpu_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> cpu_req_i);

  p_atomic_bus_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !bus_gnt_i && !fill_valid_i);
endmodule

bind msi_line_ctrl msi_line_ctrl_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_req_i     (cpu_req_i),
  .cpu_done_o    (cpu_done_o),
  .bus_req_o     (bus_req_o),
  .bus_cmd_o     (bus_cmd_o),
  .bus_gnt_i     (bus_gnt_i),
  .fill_valid_i  (fill_valid_i),
  .snp_valid_i   (snp_valid_i),
  .snp_cmd_i     (snp_cmd_i),
  .snp_reply_o   (snp_reply_o),
  .mem_inhibit_o (mem_inhibit_o)
);

// File: tb/test_msi_line_ctrl.sv
module test_msi_line_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [1:0]  cpu_op = '0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_done;
  logic [15:0] cpu_rdata;
  logic        bus_req;
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_gnt = 1'b0;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_data = '0;
  logic        snp_valid = 1'b0;
  logic [2:0]  snp_cmd = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_reply;
  logic [15:0] snp_data;
  logic        mem_inhibit;

  int n_chk = 0;
  int n_fail = 0;

  logic [11:0] got_log;
  logic        got_done;
  logic [15:0] got_rdata;
  logic [7:0]  last_wb_addr;
  logic [15:0] last_wb_data;

  always #2 clk = ~clk;

  msi_line_ctrl i_msi_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_op_i(cpu_op), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_gnt_i(bus_gnt), .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_reply_o(snp_reply), .snp_data_o(snp_data), .mem_inhibit_o(mem_inhibit)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [15:0] fill;
    logic [11:0] log;
    logic        chk;
    logic [15:0] rdata;
    logic [3:0]  req;
  } vec_t;

  // log: bus commands in order, 3 bits each (1 rd, 2 rdx, 3 upgrade, 4 wb)
  localparam vec_t VECS [16] = '{
    '{2'd0, 8'h10, 16'h0000, 16'hA001, 12'h001, 1'b1, 16'hA001, 4'd2},   // R2 miss
    '{2'd0, 8'h10, 16'h0000, 16'h0000, 12'h000, 1'b1, 16'hA001, 4'd5},   // R5 S hit
    '{2'd1, 8'h10, 16'hB002, 16'h0000, 12'h003, 1'b0, 16'h0000, 4'd4},   // R4 upgrade
    '{2'd0, 8'h10, 16'h0000, 16'h0000, 12'h000, 1'b1, 16'hB002, 4'd5},   // R5 M hit
    '{2'd1, 8'h10, 16'hB003, 16'h0000, 12'h000, 1'b0, 16'h0000, 4'd5},   // R5 store M
    '{2'd0, 8'h10, 16'h0000, 16'h0000, 12'h000, 1'b1, 16'hB003, 4'd5},
    '{2'd1, 8'h21, 16'hC001, 16'h0055, 12'h002, 1'b0, 16'h0000, 4'd3},   // R3 rdx
    '{2'd0, 8'h21, 16'h0000, 16'h0000, 12'h000, 1'b1, 16'hC001, 4'd3},
    '{2'd0 + 2'd2, 8'h21, 16'h0000, 16'h0000, 12'h004, 1'b0, 16'h0000, 4'd6}, // R6 wb
    '{2'd0, 8'h21, 16'h0000, 16'h0066, 12'h001, 1'b1, 16'h0066, 4'd6},
    '{2'd2, 8'h21, 16'h0000, 16'h0000, 12'h000, 1'b0, 16'h0000, 4'd6},   // R6 silent
    '{2'd0, 8'h21, 16'h0000, 16'h0077, 12'h001, 1'b1, 16'h0077, 4'd6},
    '{2'd0, 8'h31, 16'h0000, 16'h0088, 12'h001, 1'b1, 16'h0088, 4'd10},  // R10 S victim
    '{2'd1, 8'h41, 16'hD001, 16'h0099, 12'h002, 1'b0, 16'h0000, 4'd10},
    '{2'd0, 8'h51, 16'h0000, 16'h0012, 12'h021, 1'b1, 16'h0012, 4'd10},  // R10 M victim
    '{2'd2, 8'h13, 16'h0000, 16'h0000, 12'h000, 1'b0, 16'h0000, 4'd6}
  };

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [7:0] addr,
                         input logic [15:0] wd, input logic [15:0] fd);
    logic pend;
    pend = 1'b0;
    got_log = '0;
    got_done = 1'b0;
    got_rdata = '0;
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_op = op; cpu_addr = addr; cpu_wdata = wd; fill_data = fd;
    for (int c = 0; c < 16 && !got_done; c++) begin
      if (c > 0) begin @(posedge clk); #1; end
      bus_gnt = 1'b0;
      fill_valid = pend;
      pend = 1'b0;
      @(negedge clk);
      if (cpu_done) begin
        got_done = 1'b1;
        got_rdata = cpu_rdata;
      end else if (bus_req) begin
        got_log = {got_log[8:0], bus_cmd};
        if (bus_cmd == 3'd4) begin
          last_wb_addr = bus_addr;
          last_wb_data = bus_wdata;
        end
        if (bus_cmd == 3'd1 || bus_cmd == 3'd2) pend = 1'b1;
        bus_gnt = 1'b1;
        #1;
        if (cpu_done) begin
          got_done = 1'b1;
          got_rdata = cpu_rdata;
        end
      end
    end
    @(posedge clk); #1;
    cpu_req = 1'b0; bus_gnt = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [7:0] addr,
                       input logic exp_rep, input logic [15:0] exp_data, input string rq);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
    @(negedge clk);
    check(snp_reply == exp_rep, rq, "snoop reply", 32'(snp_reply), 32'(exp_rep));
    check(mem_inhibit == exp_rep, rq, "memory inhibit", 32'(mem_inhibit), 32'(exp_rep));
    if (exp_rep) check(snp_data == exp_data, rq, "reply data", 32'(snp_data), 32'(exp_data));
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  task automatic req_log(input logic [1:0] op, input logic [7:0] addr, input logic [15:0] wd,
                         input logic [15:0] fd, input logic [11:0] exp_log, input string rq);
    run_req(op, addr, wd, fd);
    check(got_done, rq, "request done", 32'(got_done), 32'd1);
    check(got_log == exp_log, rq, "bus command log", 32'(got_log), 32'(exp_log));
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!cpu_done && !bus_req, "R1", "request side idle", {cpu_done, bus_req}, 0);
    check(!snp_reply && !mem_inhibit, "R1", "snoop side idle", {snp_reply, mem_inhibit}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      run_req(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].fill);
      check(got_done, $sformatf("R%0d", VECS[i].req), $sformatf("row %0d done", i),
            32'(got_done), 32'd1);
      check(got_log == VECS[i].log, $sformatf("R%0d", VECS[i].req),
            $sformatf("row %0d bus log", i), 32'(got_log), 32'(VECS[i].log));
      if (VECS[i].chk)
        check(got_rdata == VECS[i].rdata, $sformatf("R%0d", VECS[i].req),
              $sformatf("row %0d load data", i), 32'(got_rdata), 32'(VECS[i].rdata));
    end
    // R10 dirty victim written back with its own address and data
    check(last_wb_addr == 8'h41, "R10", "victim wb address", 32'(last_wb_addr), 32'h41);
    check(last_wb_data == 16'hD001, "R10", "victim wb data", 32'(last_wb_data), 32'hD001);

    // R6 writeback content on evict
    req_log(2'd1, 8'h02, 16'hE101, 16'h0000, 12'h002, "R3");
    req_log(2'd2, 8'h02, 16'h0000, 16'h0000, 12'h004, "R6");
    check(last_wb_addr == 8'h02, "R6", "evict wb address", 32'(last_wb_addr), 32'h02);
    check(last_wb_data == 16'hE101, "R6", "evict wb data", 32'(last_wb_data), 32'hE101);

    // R7 snooped read on Modified: reply then Shared
    req_log(2'd1, 8'h03, 16'hF001, 16'h0000, 12'h002, "R3");
    snoop(3'd1, 8'h03, 1'b1, 16'hF001, "R7");
    req_log(2'd1, 8'h03, 16'hF002, 16'h0000, 12'h003, "R7");
    // R8 snooped rdx on Modified: reply then Invalid
    snoop(3'd2, 8'h03, 1'b1, 16'hF002, "R8");
    req_log(2'd0, 8'h03, 16'h0000, 16'h0ABC, 12'h001, "R8");
    // R9 Shared frame
    snoop(3'd1, 8'h03, 1'b0, 16'h0000, "R9");
    req_log(2'd0, 8'h03, 16'h0000, 16'h0000, 12'h000, "R9");
    check(got_rdata == 16'h0ABC, "R9", "shared data kept", 32'(got_rdata), 32'h0ABC);
    snoop(3'd3, 8'h03, 1'b0, 16'h0000, "R9");
    req_log(2'd0, 8'h03, 16'h0000, 16'h0BCD, 12'h001, "R9");
    // R13 tag miss and snooped writeback leave state alone
    snoop(3'd2, 8'h07, 1'b0, 16'h0000, "R13");
    snoop(3'd4, 8'h03, 1'b0, 16'h0000, "R13");
    req_log(2'd0, 8'h03, 16'h0000, 16'h0000, 12'h000, "R13");

    // R12 stall during a snoop
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_op = 2'd0; cpu_addr = 8'h03;
    snp_valid = 1'b1; snp_cmd = 3'd1; snp_addr = 8'h23;
    @(negedge clk);
    check(!cpu_done && !bus_req, "R12", "stalled during snoop", {cpu_done, bus_req}, 0);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    @(negedge clk);
    check(cpu_done && cpu_rdata == 16'h0BCD, "R12", "completes after snoop",
          {cpu_done, cpu_rdata}, {1'b1, 16'h0BCD});
    @(posedge clk); #1;
    cpu_req = 1'b0;

    // R11 pending upgrade loses its copy
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_op = 2'd1; cpu_addr = 8'h03; cpu_wdata = 16'h1234; fill_data = 16'h5678;
    @(negedge clk);
    check(bus_req && bus_cmd == 3'd3, "R11", "upgrade requested", {bus_req, bus_cmd}, {1'b1, 3'd3});
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_cmd = 3'd3; snp_addr = 8'h03;
    @(negedge clk);
    check(!cpu_done && !bus_req, "R12", "no request in snoop cycle", {cpu_done, bus_req}, 0);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    @(negedge clk);
    check(bus_req && bus_cmd == 3'd2, "R11", "upgrade became rdx", {bus_req, bus_cmd}, {1'b1, 3'd2});
    bus_gnt = 1'b1;
    @(posedge clk); #1;
    bus_gnt = 1'b0; fill_valid = 1'b1;
    @(negedge clk);
    check(cpu_done, "R11", "rdx done on fill", 32'(cpu_done), 32'd1);
    @(posedge clk); #1;
    cpu_req = 1'b0; fill_valid = 1'b0;

    // R11 pending writeback-eviction taken by a snoop
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_op = 2'd2; cpu_addr = 8'h03;
    @(negedge clk);
    check(bus_req && bus_cmd == 3'd4, "R11", "eviction wb requested", {bus_req, bus_cmd}, {1'b1, 3'd4});
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_cmd = 3'd2; snp_addr = 8'h03;
    @(negedge clk);
    check(snp_reply && snp_data == 16'h1234, "R8", "store data supplied", {snp_reply, snp_data},
          {1'b1, 16'h1234});
    @(posedge clk); #1;
    snp_valid = 1'b0;
    @(negedge clk);
    check(cpu_done && !bus_req, "R11", "eviction silent", {cpu_done, bus_req}, {1'b1, 1'b0});
    @(posedge clk); #1;
    cpu_req = 1'b0;
    req_log(2'd0, 8'h03, 16'h0000, 16'h0321, 12'h001, "R6");

    finish_run();
  end
endmodule